// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Receiver

This block turns one asynchronous serial line into bytes. It is paced by a sample enable that pulses sixteen times per bit cell. The line is resynchronised first. While idle, a high-to-low transition seen on a sample tick opens a frame, and that tick is numbered tick 0. The receiver takes three samples around the middle of every bit cell, on ticks 7, 8 and 9 of the cell. A 2-of-3 vote on those samples decides the bit, so one disturbed sample cannot change it.

The start cell is voted first. If the vote comes out high, the transition is treated as noise and the receiver returns to idle without reporting anything. Otherwise eight data bits follow, least significant first, and then a stop cell. Once the stop cell has been voted, the byte and a framing-error flag appear together with a one-cycle valid strobe. A new frame can only start after the line has been seen high on a tick.

Top module: `maj_uart_rx`

## Requirements
- R1: While the synchronous active-low reset is held, and in the first cycle after it, `rx_valid`, `rx_frame_err` and `rx_byte` are all 0.
- R2: `rx_line` passes through two flip-flops. A frame starts on a tick where the resynchronised line is low and was high on the previous tick, and that tick is tick 0. Frame starts happen only on tick cycles.
- R3: The start cell is decided by a 2-of-3 vote of the samples on ticks 7, 8 and 9. If the vote is high, no byte is reported and the receiver returns to idle. A single high sample among the three does not cancel the frame.
- R4: Data bit k (k = 0..7) is voted on ticks 16(k+1)+7, +8 and +9 after tick 0, and bit k lands in `rx_byte[k]`, so the byte is received least significant bit first.
- R5: Every data bit is a 2-of-3 majority. One inverted sample among ticks 7, 8 and 9 of a cell leaves the bit unchanged, two inverted samples flip it, and samples on any other tick of the cell have no effect.
- R6: The stop cell is voted on ticks 151, 152 and 153. In the clock cycle after that tick 153 edge, `rx_valid` is high for exactly one cycle. `rx_byte` and `rx_frame_err` are valid in that same cycle, and `rx_frame_err` is 1 exactly when the stop vote is low.
- R7: `rx_byte` and `rx_frame_err` change only in a cycle where `rx_valid` is high, and hold their values between strobes.
- R8: After a frame whose stop vote was low, a line that stays low starts no frame. Reception resumes only after the line has been high on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Sample enable, 16 pulses per bit cell |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_frame_err | output | 1 | Stop vote was low for the strobed byte |

## Verification
Plain frames with different bit patterns (all zeros, all ones, alternating, single bits at either end) show that bit order and cell timing are right. Frames with inverted samples placed on chosen ticks of one cell separate the three voting ticks from the rest of the cell: a single flip on tick 8 is outvoted, two flips invert the bit, and flips everywhere except ticks 7 to 9 change nothing. A short low pulse on the start cell must be rejected, while a single high start sample must not be. Stop cells with one and with two low samples, followed by a line held low, exercise the framing flag and the wait for a high line.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers for the majority-vote serial receiver.
// Assumes nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Receiver frame phases
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_phase_t;

    // Two-of-three majority of single bits
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_sync2.sv
// Module: two-stage resynchroniser for an asynchronous input.
// Assumes the input idles high; both stages reset to 1 so no false edge follows reset.
module rx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic stage1;

    // Shift the asynchronous input through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b1;
            dout   <= 1'b1;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/rx_cell_timer.sv
// Module: counts sample ticks within a bit cell.
// idx_now is the number of the tick in the current cycle (valid when tick is high).
// Assumes restart coincides with the tick that opens a frame (tick 0).
module rx_cell_timer #(
    parameter int OSR   = 16,
    localparam int IDX_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             running,
    output logic [IDX_W-1:0] idx_now
);
    logic [IDX_W-1:0] idx_q;

    // Index of the current tick: one past the last counted tick, wrapping at OSR
    always_comb begin
        if (idx_q == IDX_W'(OSR - 1)) idx_now = '0;
        else                          idx_now = idx_q + 1'b1;
    end

    // Hold the last counted tick index
    always_ff @(posedge clk) begin
        if (!rst_n)                  idx_q <= '0;
        else if (restart)            idx_q <= '0;
        else if (running && tick)    idx_q <= idx_now;
    end
endmodule

// File: rtl/rx_voter.sv
// Module: takes three samples around mid-cell and issues a 2-of-3 decision.
// Samples on ticks MID-1 and MID are stored; the decision is formed on tick MID+1
// from the stored pair and the live sample. Assumes OSR >= 4.
module rx_voter
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    localparam int IDX_W = $clog2(OSR),
    localparam int MID   = OSR / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic [IDX_W-1:0] idx_now,
    input  logic             din,
    output logic             decide,
    output logic             vote
);
    logic samp_a, samp_b;

    // Capture the early and centre samples of the cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick && active) begin
            if (idx_now == IDX_W'(MID - 1)) samp_a <= din;
            if (idx_now == IDX_W'(MID))     samp_b <= din;
        end
    end

    // Decide on the late sample tick
    always_comb begin
        decide = tick && active && (idx_now == IDX_W'(MID + 1));
        vote   = maj3(samp_a, samp_b, din);
    end
endmodule

// File: rtl/maj_uart_rx.sv
// Module: oversampling serial receiver with majority-voted bits.
// A start, DATA_BITS data bits (LSB first) and one stop bit, each OSR ticks long.
// Assumes tick_en pulses OSR times per bit and at most once per clock cycle.
module maj_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    localparam int IDX_W    = $clog2(OSR),
    localparam int BC_W     = $clog2(DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    rx_phase_t             phase_q;
    logic                  line_s;
    logic                  line_prev;
    logic                  edge_seen;
    logic                  busy;
    logic [IDX_W-1:0]      idx_now;
    logic                  decide;
    logic                  vote;
    logic [BC_W-1:0]       bit_cnt;
    logic [DATA_BITS-1:0]  shreg;

    rx_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    // Frame-opening edge and busy indication
    always_comb begin
        busy      = (phase_q != RX_IDLE);
        edge_seen = tick_en && !busy && line_prev && !line_s;
    end

    rx_cell_timer #(.OSR(OSR)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .restart (edge_seen),
        .running (busy),
        .idx_now (idx_now)
    );

    rx_voter #(.OSR(OSR)) u_voter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .active  (busy),
        .idx_now (idx_now),
        .din     (line_s),
        .decide  (decide),
        .vote    (vote)
    );

    // Track the line level seen on the previous tick
    always_ff @(posedge clk) begin
        if (!rst_n)       line_prev <= 1'b1;
        else if (tick_en) line_prev <= line_s;
    end

    // Frame sequencing, shifting and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= RX_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (phase_q)
                RX_IDLE: begin
                    if (edge_seen) phase_q <= RX_START;
                end
                RX_START: begin
                    if (decide) begin
                        bit_cnt <= '0;
                        phase_q <= vote ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (decide) begin
                        shreg <= {vote, shreg[DATA_BITS-1:1]};
                        if (bit_cnt == BC_W'(DATA_BITS - 1)) phase_q <= RX_STOP;
                        else                                 bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (decide) begin
                        rx_byte      <= shreg;
                        rx_frame_err <= !vote;
                        rx_valid     <= 1'b1;
                        phase_q      <= RX_IDLE;
                    end
                end
                default: phase_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/maj_uart_rx_chk.sv
// Module: property checker bound to the receiver top.
// Assumes the ports are connected to the top's own signals by the bind below.
module maj_uart_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 busy,
    input logic [DATA_BITS-1:0] rx_byte,
    input logic                 rx_valid,
    input logic                 rx_frame_err
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && !rx_frame_err && rx_byte == '0));

    p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick_en));

    p_strobe_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_strobe_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(tick_en) && $past(busy) && !busy));

    p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_valid);

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_frame_err) |-> rx_valid);
endmodule

bind maj_uart_rx maj_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .busy         (busy),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
);

// File: tb/tb_maj_uart_rx.sv
module tb_maj_uart_rx;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] b;
        logic       fe;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] tdiv = '0;
    logic       tick_en;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_frame_err;

    int   n_checks = 0;
    int   n_errors = 0;
    int   n_valid  = 0;
    int   n_hold_bad = 0;
    bit   finished = 0;
    exp_t sb[$];
    logic [7:0] last_byte = '0;
    logic       last_fe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick every fourth cycle
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick_en = (tdiv == 2'd3);

    maj_uart_rx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .rx_line      (rx_line),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One tick slot: the value is applied just after a tick edge
    task automatic slot(input logic v);
        @(negedge clk iff tick_en);
        @(posedge clk);
        #1 rx_line = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    // Drive a full frame; cells 0..9 = start, data LSB first, stop.
    // Offsets set in fmask within cell fcell are inverted.
    task automatic send(input logic [7:0] d, input logic stopv, input int fcell,
                        input logic [15:0] fmask, input logic [7:0] eb,
                        input logic efe, input string req);
        exp_t e;
        e.b = eb; e.fe = efe; e.req = req;
        sb.push_back(e);
        for (int c = 0; c < 10; c++) begin
            logic cv;
            cv = (c == 0) ? 1'b0 : (c == 9) ? stopv : d[c-1];
            for (int o = 0; o < 16; o++)
                slot((c == fcell && fmask[o]) ? ~cv : cv);
        end
    endtask

    // Monitor: pop and compare each strobed result; track holding between strobes
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_valid) begin
                n_valid++;
                if (sb.size() == 0) begin
                    check(1'b0, "R3/R8", "unexpected strobe byte", rx_byte, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rx_byte == e.b && rx_frame_err == e.fe, e.req,
                          "byte/frame_err", {rx_frame_err, rx_byte}, {e.fe, e.b});
                end
                last_byte = rx_byte;
                last_fe   = rx_frame_err;
            end else if (rx_byte !== last_byte || rx_frame_err !== last_fe) begin
                n_hold_bad++;
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        int v0;
        repeat (5) @(posedge clk);
        #1;
        // R1: outputs quiet in reset
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        check(rx_frame_err == 1'b0, "R1", "rx_frame_err in reset", rx_frame_err, 0);
        check(rx_byte == 8'h00, "R1", "rx_byte in reset", rx_byte, 0);
        rst_n = 1'b1;
        idle(8);

        // R2 R4 R6: plain frames with distinct patterns
        send(8'hA5, 1'b1, -1, '0, 8'hA5, 1'b0, "R4");
        idle(3);
        send(8'h00, 1'b1, -1, '0, 8'h00, 1'b0, "R2");
        idle(3);
        send(8'hFF, 1'b1, -1, '0, 8'hFF, 1'b0, "R4");
        idle(3);
        send(8'h01, 1'b1, -1, '0, 8'h01, 1'b0, "R4");
        send(8'h80, 1'b1, -1, '0, 8'h80, 1'b0, "R6");   // back to back
        idle(3);

        // R5: one flipped sample outvoted; off-centre flips ignored; two flips win
        send(8'h3C, 1'b1, 4, 16'h0100, 8'h3C, 1'b0, "R5");
        idle(3);
        send(8'h55, 1'b1, 1, 16'hFC7F, 8'h55, 1'b0, "R5");
        idle(3);
        send(8'h12, 1'b1, 8, 16'h0280, 8'h92, 1'b0, "R5");
        idle(3);

        // R3: single high start sample does not cancel the frame
        send(8'h9E, 1'b1, 0, 16'h0080, 8'h9E, 1'b0, "R3");
        idle(3);
        // R3: short start pulse (low on ticks 0..7 only) is rejected
        v0 = n_valid;
        for (int i = 0; i < 8; i++) slot(1'b0);
        idle(180);
        check(n_valid == v0, "R3", "strobes after rejected start", n_valid - v0, 0);

        // R6: stop cell with one low sample is fine, with two low samples is an error
        send(8'h6B, 1'b1, 9, 16'h0100, 8'h6B, 1'b0, "R6");
        idle(3);
        send(8'h6C, 1'b1, 9, 16'h0300, 8'h6C, 1'b1, "R6");
        idle(3);

        // R6 R8: low stop, then line held low: no further frame
        send(8'h77, 1'b0, -1, '0, 8'h77, 1'b1, "R6");
        v0 = n_valid;
        for (int i = 0; i < 200; i++) slot(1'b0);
        check(n_valid == v0, "R8", "strobes while line stays low", n_valid - v0, 0);
        idle(20);
        send(8'hC3, 1'b1, -1, '0, 8'hC3, 1'b0, "R8");
        idle(10);

        check(sb.size() == 0, "R6", "expected bytes not received", sb.size(), 0);
        check(n_hold_bad == 0, "R7", "output changed without strobe", n_hold_bad, 0);
        finish_run();
    end
endmodule